// File: doc/BRIEF.md
# Address-Gated Serial Divider Loader

This block sits between a system controller and a frequency synthesizer's divider logic. The controller programs three divider values over a three-wire serial link: a bit clock, a data line and a load strobe. The block only listens while its 3-bit module address is present on the address inputs, so several such blocks can share one link. The serial lines are asynchronous to the system clock. They are synchronised, and their edges are detected, in the system clock domain.

Each frame is 32 bits long and is sent most-significant bit first. It holds a 14-bit reference divider, a 10-bit main divider and a 7-bit swallow divider, followed by one control bit. On a rising edge of the load strobe, the block copies the three fields into holding registers, but only if the control bit at the end of the frame is 1. When it does so, it emits a one-cycle load pulse. A valid flag shows that at least one frame has been committed.

Top module: `serial_divider_loader`

## Requirements
- R1: After reset, r_o, n_o and a_o are zero, and valid_o and load_o are low.
- R2: While the address matches, each rising edge of ser_clk_i shifts ser_data_i into the shift register. The first bit lands at frame bit 31 after 32 bits have been sent. In frame bit positions, R is 31..18, N is 17..8, A is 7..1 and the control bit is bit 0, the last bit sent.
- R3: A rising edge of ser_en_i while the address matches and the control bit is 1 loads r_o, n_o and a_o from the frame. At the same time load_o goes high for exactly one system-clock cycle.
- R4: A rising edge of ser_en_i while the control bit is 0 produces no load_o pulse, and r_o, n_o and a_o keep their previous values.
- R5: The address matches only when addr_i equals 3'b010 (addr_i[0]=0, addr_i[1]=1, addr_i[2]=0). While it does not match, ser_clk_i edges are ignored and the shift register keeps its contents.
- R6: A rising edge of ser_en_i while the address does not match produces no load, and the latched values are unchanged.
- R7: valid_o stays low until the first committed load. It then stays high until the next reset.
- R8: If more than 32 bits are clocked in before the load strobe, only the last 32 bits are used.
- R9: Holding ser_en_i high produces only one load. A new load needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Module address lines |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_data_i | input | 1 | Serial data (asynchronous) |
| ser_en_i | input | 1 | Load strobe (asynchronous) |
| r_o | output | 14 | Latched reference divider |
| n_o | output | 10 | Latched main divider |
| a_o | output | 7 | Latched swallow divider |
| valid_o | output | 1 | At least one frame committed |
| load_o | output | 1 | One-cycle pulse on each commit |

## Verification
The bench uses frames whose field values are asymmetric, so that a design that reversed the bit order or misplaced a field boundary would latch visibly wrong R, N or A values.

It sends a frame whose control bit is clear, clocks in bits and pulses the strobe while the address is wrong, and overfills the shift register with extra leading bits. A design that ignored the control bit, leaked the link through a wrong address, or took the oldest bits would produce an unexpected load or wrong latched values.

It also holds the strobe high for a long time. A level-triggered design would then issue repeated load pulses or a pulse wider than one cycle.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned R_W    = 14;
  localparam int unsigned N_W    = 10;
  localparam int unsigned A_W    = 7;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] MATCH_ADDR = 3'b010;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sdl_edge_gate.sv
module sdl_edge_gate #(
  parameter int unsigned ADDR_W = 3,
  parameter logic [ADDR_W-1:0] MATCH_ADDR = 3'b010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_s_i,
  input  logic              sclk_s_i,
  input  logic              en_s_i,
  output logic              shift_o,
  output logic              commit_o
);
  logic sclk_prev_q, en_prev_q, match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      en_prev_q   <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      en_prev_q   <= en_s_i;
    end
  end

  assign match    = (addr_s_i == MATCH_ADDR);
  assign shift_o  = match & sclk_s_i & ~sclk_prev_q;
  assign commit_o = match & en_s_i & ~en_prev_q;

  AST_COMMIT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R9
endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               data_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], data_i};
  end

  assign frame_o = sr_q;

  AST_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q)); // R5
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[0] == $past(data_i)); // R2
endmodule

// File: rtl/sdl_latch.sv
module sdl_latch #(
  parameter int unsigned R_W = 14,
  parameter int unsigned N_W = 10,
  parameter int unsigned A_W = 7,
  localparam int unsigned FRAME_W = R_W + N_W + A_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [R_W-1:0]     r_o,
  output logic [N_W-1:0]     n_o,
  output logic [A_W-1:0]     a_o,
  output logic               valid_o,
  output logic               load_o
);
  localparam int unsigned A_LSB = 1;
  localparam int unsigned N_LSB = A_LSB + A_W;
  localparam int unsigned R_LSB = N_LSB + N_W;

  logic [R_W-1:0] r_q;
  logic [N_W-1:0] n_q;
  logic [A_W-1:0] a_q;
  logic valid_q, load_q, take;

  // control bit is the last one shifted in
  assign take = commit_i & frame_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q     <= '0;
      n_q     <= '0;
      a_q     <= '0;
      valid_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= take;
      if (take) begin
        r_q     <= frame_i[R_LSB +: R_W];
        n_q     <= frame_i[N_LSB +: N_W];
        a_q     <= frame_i[A_LSB +: A_W];
        valid_q <= 1'b1;
      end
    end
  end

  assign r_o     = r_q;
  assign n_o     = n_q;
  assign a_o     = a_q;
  assign valid_o = valid_q;
  assign load_o  = load_q;

  AST_NO_COMMIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(r_q) && $stable(n_q) && $stable(a_q) && !load_q); // R6
  AST_CTRL_CLEAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !frame_i[0]) |=> !load_q && $stable(r_q)); // R4
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q); // R7
  AST_LOAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> valid_q); // R7
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q); // R3
endmodule

// File: rtl/serial_divider_loader.sv
module serial_divider_loader #(
  parameter int unsigned R_W    = sdl_pkg::R_W,
  parameter int unsigned N_W    = sdl_pkg::N_W,
  parameter int unsigned A_W    = sdl_pkg::A_W,
  parameter int unsigned ADDR_W = sdl_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] MATCH_ADDR = sdl_pkg::MATCH_ADDR,
  parameter int unsigned SYNC_STAGES = sdl_pkg::SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_en_i,
  output logic [R_W-1:0]    r_o,
  output logic [N_W-1:0]    n_o,
  output logic [A_W-1:0]    a_o,
  output logic              valid_o,
  output logic              load_o
);
  localparam int unsigned FRAME_W = R_W + N_W + A_W + 1;
  localparam int unsigned SYNC_W  = ADDR_W + 3;

  logic [SYNC_W-1:0]  sync_d, sync_q;
  logic [ADDR_W-1:0]  addr_s;
  logic               sclk_s, data_s, en_s;
  logic               shift, commit;
  logic [FRAME_W-1:0] frame;

  // address shares the synchroniser so it aligns with the serial lines
  assign sync_d = {addr_i, ser_en_i, ser_data_i, ser_clk_i};

  sdl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_d), .q_o(sync_q)
  );

  assign sclk_s = sync_q[0];
  assign data_s = sync_q[1];
  assign en_s   = sync_q[2];
  assign addr_s = sync_q[SYNC_W-1:3];

  sdl_edge_gate #(.ADDR_W(ADDR_W), .MATCH_ADDR(MATCH_ADDR)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_s_i(addr_s),
    .sclk_s_i(sclk_s), .en_s_i(en_s), .shift_o(shift), .commit_o(commit)
  );

  sdl_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift), .data_i(data_s),
    .frame_o(frame)
  );

  sdl_latch #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .frame_i(frame),
    .r_o(r_o), .n_o(n_o), .a_o(a_o), .valid_o(valid_o), .load_o(load_o)
  );
endmodule

// File: tb/serial_divider_loader_bench.sv
module serial_divider_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = 3'b000;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic [13:0] r_o;
  logic [9:0]  n_o;
  logic [6:0]  a_o;
  logic valid_o, load_o;

  localparam logic [2:0] GOOD = 3'b010;
  localparam logic [2:0] BAD  = 3'b011;

  typedef struct packed { logic [13:0] r; logic [9:0] n; logic [6:0] a; } exp_t;
  exp_t exp_q[$];
  exp_t last;
  int checks = 0, errors = 0, loads = 0, exp_loads = 0;
  logic prev_load = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  serial_divider_loader u_serial_divider_loader (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ser_clk_i(sclk),
    .ser_data_i(sdata), .ser_en_i(sen), .r_o(r_o), .n_o(n_o), .a_o(a_o),
    .valid_o(valid_o), .load_o(load_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b, input logic [2:0] ad);
    addr = ad; sdata = b;
    wclk(4); sclk = 1'b1;
    wclk(4); sclk = 1'b0;
    wclk(4);
  endtask

  task automatic send_frame(input exp_t f, input logic ctrl, input logic [2:0] ad);
    logic [31:0] w;
    w = {f.r, f.n, f.a, ctrl};
    for (int i = 31; i >= 0; i--) send_bit(w[i], ad);
  endtask

  task automatic pulse_en(input logic [2:0] ad, input int hold, input logic expect_load, input exp_t f);
    if (expect_load) begin
      exp_q.push_back(f);
      exp_loads++;
      last = f;
    end
    addr = ad; wclk(4);
    sen = 1'b1; wclk(hold);
    sen = 1'b0; wclk(8);
    addr = GOOD;
  endtask

  task automatic chk_outs(input string tag);
    @(negedge clk);
    chk(r_o == last.r, tag, 32'(r_o), 32'(last.r));
    chk(n_o == last.n, tag, 32'(n_o), 32'(last.n));
    chk(a_o == last.a, tag, 32'(a_o), 32'(last.a));
  endtask

  // monitor: pops expected commits as load pulses appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_o) begin
        exp_t e;
        loads++;
        checks++;
        if (prev_load) begin
          errors++;
          $display("FAIL R3/R9 load pulse wider than one cycle actual=1 expected=0");
        end else if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4/R6 unexpected load actual=%h expected=none", {r_o, n_o, a_o});
        end else begin
          e = exp_q.pop_front();
          if ({r_o, n_o, a_o} !== e) begin
            errors++;
            $display("FAIL R2/R3 latched actual=%h expected=%h", {r_o, n_o, a_o}, e);
          end
        end
      end
      prev_load = load_o;
    end
  end

  initial begin
    wclk(200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t f1, f2, f3, f4, f5, f6, junk;
    last = '0;
    wclk(3);
    @(negedge clk);
    // R1 reset state
    chk(r_o == 0 && n_o == 0 && a_o == 0, "R1 dividers zero", {r_o, n_o, a_o}, 0);
    chk(!valid_o && !load_o, "R1 flags low", {valid_o, load_o}, 0);
    rst_n = 1'b1;
    wclk(3);

    // R2 R3 R7: basic commit
    f1 = '{r: 14'h1ABC, n: 10'h2C3, a: 7'h55};
    send_frame(f1, 1'b1, GOOD);
    @(negedge clk);
    chk(!valid_o, "R7 valid low before first load", 32'(valid_o), 0);
    pulse_en(GOOD, 6, 1'b1, f1);
    chk_outs("R2 R3 first frame");
    chk(valid_o, "R7 valid after load", 32'(valid_o), 1);

    // R4: control bit clear
    f2 = '{r: 14'h0F0F, n: 10'h155, a: 7'h2A};
    send_frame(f2, 1'b0, GOOD);
    pulse_en(GOOD, 6, 1'b0, f2);
    chk_outs("R4 ctrl clear keeps values");

    // R5: bits with wrong address are ignored
    f3 = '{r: 14'h2468, n: 10'h3A5, a: 7'h13};
    send_frame(f3, 1'b1, GOOD);
    for (int i = 0; i < 7; i++) send_bit(i[0], BAD);
    pulse_en(GOOD, 6, 1'b1, f3);
    chk_outs("R5 wrong address clocks ignored");

    // R6: strobe with wrong address
    f4 = '{r: 14'h3FFF, n: 10'h000, a: 7'h7F};
    send_frame(f4, 1'b1, GOOD);
    pulse_en(BAD, 6, 1'b0, f4);
    chk_outs("R6 wrong address strobe ignored");
    chk(loads == exp_loads, "R6 load count", loads, exp_loads);
    pulse_en(GOOD, 6, 1'b1, f4);
    chk_outs("R6 frame retained then loaded");

    // R8: overfill, last 32 bits win
    f5 = '{r: 14'h0001, n: 10'h200, a: 7'h40};
    junk = '{r: 14'h3FFF, n: 10'h3FF, a: 7'h7F};
    for (int i = 0; i < 9; i++) send_bit(1'b1, GOOD);
    send_frame(f5, 1'b1, GOOD);
    pulse_en(GOOD, 6, 1'b1, f5);
    chk_outs("R8 last 32 bits used");
    chk({r_o, n_o, a_o} != junk, "R8 not leading bits", {r_o, n_o, a_o}, f5);

    // R9: long strobe gives one load
    f6 = '{r: 14'h2001, n: 10'h1E1, a: 7'h0C};
    send_frame(f6, 1'b1, GOOD);
    pulse_en(GOOD, 60, 1'b1, f6);
    chk_outs("R9 long strobe");
    chk(loads == exp_loads, "R9 load count", loads, exp_loads);
    chk(valid_o, "R7 valid sticky", 32'(valid_o), 1);

    wclk(10);
    chk(exp_q.size() == 0, "R3 all expected loads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule